// File: doc/BRIEF.md
# Five-Phase Virtual-Vector Symmetric PWM Sequencer

This block produces the five gate-level switching signals of a two-level five-phase inverter, one complete pattern per sampling period. An upstream controller supplies a sector number and two durations, one for each of the two virtual vectors that bracket the reference. Each virtual vector is a blend of three neighbouring large switching states, weighted by two fixed fractions (one outer, one inner). For a given sector the two blends overlap, so four distinct large states are involved. The block works out how long each of the four is on, then plays them as a centre-symmetric pattern over a free-running period counter.

The zero states (all legs low, all legs high) are never produced. Every pattern uses only the ten large states, which keeps the common-mode excursion at its minimum. Neighbouring large states differ in one leg only, so within a period each change of state toggles exactly one output. Inputs are taken only at the period boundary. A one-clock strobe at each period start tells the controller when its next inputs will be consumed.

Top module: `vvpwm_sequencer`

## Requirements
- R1: While `rst_i` is high, `pwm_o` is 0 and `strobe_o` is low. The first rising edge with `rst_i` low samples the inputs and starts a period, so `strobe_o` is high in the cycle that follows.
- R2: A period lasts exactly `PERIOD` clocks. `strobe_o` is high for the first clock of each period and low for all the others.
- R3: `sector_i`, `t1_i` and `t2_i` are sampled only on the edge that ends a period. A change in the middle of a period leaves the rest of that period unchanged.
- R4: The ten large states, with bit 4 driving the first phase leg, are held in this circular table at index 0 to 9: 10001, 11001, 11000, 11100, 01100, 01110, 00110, 00111, 00011, 10011. Sector k (1 to 10) uses table entries k-1, k, k+1 and k+2, taken modulo 10. Sector 10 therefore wraps to entries 9, 0, 1 and 2.
- R5: With Q = 2^FRAC_W, the dwell times of the four states in table order are floor(D1·T1/Q), floor((D2·T1+D1·T2)/Q), floor((D1·T1+D2·T2)/Q) and floor(D1·T2/Q). The fixed fractions satisfy 2·D1+D2 = Q.
- R6: The first half of a period plays the first three states in table order, each for floor(dwell/2) clocks. The fourth state then fills the centre up to the mirror point, so it absorbs all rounding. The second half plays the first three states again, in reverse order and for the same counts. A state whose half count is 0 is skipped.
- R7: Whenever `pwm_o` is non-zero, it has exactly two or three bits set. It is never 11111. Once a valid pattern has been loaded, `pwm_o` is never 0.
- R8: Within a period, consecutive values of `pwm_o` differ in at most one bit. This holds whenever D1·PERIOD ≥ 2·Q, which keeps the two middle dwell times non-zero.
- R9: A sector outside 1 to 10, sampled at a period boundary, is ignored. The previous valid pattern repeats in the next period. If no valid pattern has been loaded since reset, `pwm_o` stays 0.
- R10: If t1_i + t2_i ≠ PERIOD at a period boundary, the inputs are likewise ignored and the previous pattern repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sector_i | input | 4 | Sector number, 1 to 10 valid |
| t1_i | input | CNT_W | Clocks given to the lower virtual vector |
| t2_i | input | CNT_W | Clocks given to the upper virtual vector |
| pwm_o | output | 5 | Leg switching states, bit 4 drives the first phase |
| strobe_o | output | 1 | High for the first clock of each period |

## Verification
The inputs are loaded on the edge that ends a period, so a value driven at any point inside period n shapes every cycle of period n+1. Its first output appears in the cycle where `strobe_o` is high. Count i of that period is visible i cycles after the strobe, because `pwm_o` is decoded without further delay from the registered counter and the latched edges. The bench therefore aligns itself to the strobe and samples each count at the falling edge. It drives the next inputs halfway through the period under check, so it can confirm that the remaining half does not move, and it expects the new inputs only after the next strobe.

// File: rtl/vvpwm_pkg.sv
package vvpwm_pkg;

    typedef logic [4:0] leg_t;

    localparam int unsigned NUM_LV = 10;

    // Circular large-state table; neighbours differ in one leg.
    function automatic leg_t lv_state(input logic [3:0] idx);
        leg_t s;
        case (idx)
            4'd0:    s = 5'b10001;
            4'd1:    s = 5'b11001;
            4'd2:    s = 5'b11000;
            4'd3:    s = 5'b11100;
            4'd4:    s = 5'b01100;
            4'd5:    s = 5'b01110;
            4'd6:    s = 5'b00110;
            4'd7:    s = 5'b00111;
            4'd8:    s = 5'b00011;
            4'd9:    s = 5'b10011;
            default: s = 5'b10001;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/vvpwm_plan.sv
module vvpwm_plan #(
    parameter int unsigned PERIOD = 5000,
    parameter int unsigned FRAC_W = 8,
    parameter int unsigned D1_Q   = 71,
    parameter int unsigned D2_Q   = 114,
    parameter int unsigned CNT_W  = 13
) (
    input  logic [CNT_W-1:0] t1_i,
    input  logic [CNT_W-1:0] t2_i,
    output logic [CNT_W-1:0] edge_a_o,
    output logic [CNT_W-1:0] edge_b_o,
    output logic [CNT_W-1:0] edge_c_o
);
    localparam int unsigned PW = CNT_W + FRAC_W + 1;
    localparam logic [PW-1:0] D1_W = PW'(D1_Q);
    localparam logic [PW-1:0] D2_W = PW'(D2_Q);

    logic [PW-1:0]    t1_w, t2_w;
    logic [PW-1:0]    dw_full [4];
    logic [CNT_W-1:0] half    [4];

    always_comb begin
        t1_w       = PW'(t1_i);
        t2_w       = PW'(t2_i);
        dw_full[0] = (D1_W * t1_w) >> FRAC_W;
        dw_full[1] = (D2_W * t1_w + D1_W * t2_w) >> FRAC_W;
        dw_full[2] = (D1_W * t1_w + D2_W * t2_w) >> FRAC_W;
        dw_full[3] = (D1_W * t2_w) >> FRAC_W;
    end

    for (genvar g = 0; g < 4; g++) begin : g_half
        assign half[g] = CNT_W'(dw_full[g] >> 1);
    end

    // Rising edges of the first-half segments; the centre takes the rest.
    assign edge_a_o = half[0];
    assign edge_b_o = half[0] + half[1];
    assign edge_c_o = half[0] + half[1] + half[2];

endmodule

// File: rtl/vvpwm_decode.sv
module vvpwm_decode
    import vvpwm_pkg::*;
#(
    parameter int unsigned PERIOD = 5000,
    parameter int unsigned CNT_W  = 13
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] edge_a_i,
    input  logic [CNT_W-1:0] edge_b_i,
    input  logic [CNT_W-1:0] edge_c_i,
    input  logic [3:0]       base_i,
    input  logic             vld_i,
    output leg_t             pwm_o
);
    localparam logic [CNT_W-1:0] P_W = CNT_W'(PERIOD);

    logic [1:0] seg;
    logic [4:0] idx_sum;
    logic [4:0] idx;

    always_comb begin
        if (cnt_i < edge_a_i)             seg = 2'd0;
        else if (cnt_i < edge_b_i)        seg = 2'd1;
        else if (cnt_i < edge_c_i)        seg = 2'd2;
        else if (cnt_i < P_W - edge_c_i)  seg = 2'd3;
        else if (cnt_i < P_W - edge_b_i)  seg = 2'd2;
        else if (cnt_i < P_W - edge_a_i)  seg = 2'd1;
        else                              seg = 2'd0;

        idx_sum = 5'(base_i) + 5'(seg);
        idx     = (idx_sum >= 5'(NUM_LV)) ? idx_sum - 5'(NUM_LV) : idx_sum;
        pwm_o   = vld_i ? lv_state(idx[3:0]) : '0;
    end

endmodule

// File: rtl/vvpwm_sequencer.sv
module vvpwm_sequencer
    import vvpwm_pkg::*;
#(
    parameter int unsigned PERIOD = 5000,
    parameter int unsigned FRAC_W = 8,
    parameter int unsigned D1_Q   = 71,
    parameter int unsigned D2_Q   = 114,
    localparam int unsigned CNT_W = $clog2(PERIOD + 1)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [3:0]       sector_i,
    input  logic [CNT_W-1:0] t1_i,
    input  logic [CNT_W-1:0] t2_i,
    output logic [4:0]       pwm_o,
    output logic             strobe_o
);
    localparam logic [CNT_W-1:0] P_W   = CNT_W'(PERIOD);
    localparam logic [CNT_W-1:0] LAST  = P_W - 1'b1;
    localparam logic [CNT_W:0]   P_SUM = (CNT_W+1)'(PERIOD);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [3:0]       base;
        logic [CNT_W-1:0] ea;
        logic [CNT_W-1:0] eb;
        logic [CNT_W-1:0] ec;
        logic             vld;
    } seq_t;

    localparam seq_t SEQ_RST = '{cnt: LAST, base: '0, ea: '0, eb: '0, ec: '0, vld: 1'b0};

    seq_t             seq_d, seq_q;
    logic [CNT_W-1:0] ea_new, eb_new, ec_new;
    logic             at_end;
    logic             plan_ok;

    vvpwm_plan #(
        .PERIOD (PERIOD),
        .FRAC_W (FRAC_W),
        .D1_Q   (D1_Q),
        .D2_Q   (D2_Q),
        .CNT_W  (CNT_W)
    ) u_plan (
        .t1_i     (t1_i),
        .t2_i     (t2_i),
        .edge_a_o (ea_new),
        .edge_b_o (eb_new),
        .edge_c_o (ec_new)
    );

    always_comb begin
        seq_d   = seq_q;
        at_end  = (seq_q.cnt == LAST);
        plan_ok = (sector_i >= 4'd1) && (sector_i <= 4'd10) &&
                  (({1'b0, t1_i} + {1'b0, t2_i}) == P_SUM);
        if (at_end) begin
            seq_d.cnt = '0;
            if (plan_ok) begin
                seq_d.base = sector_i - 4'd1;
                seq_d.ea   = ea_new;
                seq_d.eb   = eb_new;
                seq_d.ec   = ec_new;
                seq_d.vld  = 1'b1;
            end
        end else begin
            seq_d.cnt = seq_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) seq_q <= SEQ_RST;
        else       seq_q <= seq_d;
    end

    vvpwm_decode #(
        .PERIOD (PERIOD),
        .CNT_W  (CNT_W)
    ) u_decode (
        .cnt_i    (seq_q.cnt),
        .edge_a_i (seq_q.ea),
        .edge_b_i (seq_q.eb),
        .edge_c_i (seq_q.ec),
        .base_i   (seq_q.base),
        .vld_i    (seq_q.vld),
        .pwm_o    (pwm_o)
    );

    assign strobe_o = (seq_q.cnt == '0);

    assert_reset_quiet_R1: assert property (@(posedge clk_i)
        rst_i |=> (pwm_o == 5'b0 && !strobe_o));

    assert_strobe_single_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        strobe_o |=> !strobe_o);

    assert_count_range_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        seq_q.cnt < P_W);

    assert_hold_mid_period_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (seq_q.cnt != '0) |-> $stable({seq_q.base, seq_q.ea, seq_q.eb, seq_q.ec, seq_q.vld}));

    assert_large_only_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (pwm_o != 5'b0) |-> ($countones(pwm_o) == 2 || $countones(pwm_o) == 3));

    assert_no_zero_after_load_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        seq_q.vld |-> (pwm_o != 5'b0));

    assert_single_toggle_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (seq_q.cnt != '0) |-> ($countones(pwm_o ^ $past(pwm_o)) <= 1));

    assert_invalid_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (at_end && !plan_ok) |=> $stable({seq_q.base, seq_q.ea, seq_q.eb, seq_q.ec, seq_q.vld}));

endmodule

// File: tb/test_vvpwm_sequencer.sv
`timescale 1ns/1ps
module test_vvpwm_sequencer;

    localparam int P  = 40;
    localparam int FW = 8;
    localparam int D1 = 71;
    localparam int D2 = 114;
    localparam int CW = $clog2(P + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    sector = 4'd0;
    logic [CW-1:0] t1 = '0;
    logic [CW-1:0] t2 = '0;
    logic [4:0]    pwm;
    logic          strobe;

    int checks = 0;
    int fails  = 0;

    int cur_s = 0, cur_t1 = 0, cur_t2 = 0;
    bit cur_vld = 1'b0;

    logic [4:0] lv_tab [10] = '{5'b10001, 5'b11001, 5'b11000, 5'b11100, 5'b01100,
                                5'b01110, 5'b00110, 5'b00111, 5'b00011, 5'b10011};

    always #10 clk = ~clk;

    vvpwm_sequencer #(.PERIOD(P), .FRAC_W(FW), .D1_Q(D1), .D2_Q(D2)) i_vvpwm_sequencer (
        .clk_i    (clk),
        .rst_i    (rst),
        .sector_i (sector),
        .t1_i     (t1),
        .t2_i     (t2),
        .pwm_o    (pwm),
        .strobe_o (strobe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [4:0] exp_pwm(input int s, input int a1, input int a2, input int i);
        int q, h0, h1, h2, ea, eb, ec, seg;
        q  = 1 << FW;
        h0 = ((D1 * a1) / q) / 2;
        h1 = ((D2 * a1 + D1 * a2) / q) / 2;
        h2 = ((D1 * a1 + D2 * a2) / q) / 2;
        ea = h0; eb = h0 + h1; ec = h0 + h1 + h2;
        if (i < ea)          seg = 0;
        else if (i < eb)     seg = 1;
        else if (i < ec)     seg = 2;
        else if (i < P - ec) seg = 3;
        else if (i < P - eb) seg = 2;
        else if (i < P - ea) seg = 1;
        else                 seg = 0;
        return lv_tab[(s - 1 + seg) % 10];
    endfunction

    // One period, starting at the falling edge where strobe is high.
    task automatic run_period(input int ns, input int nt1, input int nt2, input string tag);
        logic [4:0] prev = pwm;
        logic [4:0] exp;
        for (int i = 0; i < P; i++) begin
            exp = cur_vld ? exp_pwm(cur_s, cur_t1, cur_t2, i) : 5'b0;
            check(pwm == exp, (i > P / 2) ? {tag, " R3"} : tag, int'(pwm), int'(exp));
            check(strobe == (i == 0), "R2", int'(strobe), (i == 0) ? 1 : 0);
            if (cur_vld)
                check($countones(pwm) == 2 || $countones(pwm) == 3, "R7",
                      $countones(pwm), 2);
            if (i > 0)
                check($countones(pwm ^ prev) <= 1, "R8", $countones(pwm ^ prev), 1);
            prev = pwm;
            if (i == P / 2) begin
                sector = 4'(ns);
                t1     = CW'(nt1);
                t2     = CW'(nt2);
            end
            @(negedge clk);
        end
        if (ns >= 1 && ns <= 10 && nt1 + nt2 == P) begin
            cur_s = ns; cur_t1 = nt1; cur_t2 = nt2; cur_vld = 1'b1;
        end
    endtask

    initial begin
        repeat (3) begin
            @(negedge clk);
            check(pwm == 5'b0, "R1", int'(pwm), 0);
            check(strobe == 1'b0, "R1", int'(strobe), 0);
        end
        rst = 1'b0;
        @(negedge clk);
        check(strobe == 1'b1, "R1", int'(strobe), 1);

        // No valid pattern yet: outputs stay low (R9).
        run_period(1, 0, P, "R9");

        // Every sector against every split of the period (R4 R5 R6).
        for (int s = 1; s <= 10; s++) begin
            for (int a = 0; a <= P; a++) begin
                int ns, na;
                ns = s; na = a + 1;
                if (na > P) begin ns = s + 1; na = 0; end
                if (ns > 10) begin ns = 13; na = 5; end
                run_period(ns, na, P - na, "R4 R5 R6");
            end
        end

        // Out-of-range sector was just loaded: previous pattern repeats (R9).
        run_period(0, 10, P - 10, "R9");
        run_period(15, 20, P - 20, "R9");
        // Sum mismatch now sampled; previous pattern must repeat (R10).
        run_period(4, 10, 20, "R9");
        run_period(7, 12, P - 12, "R10");
        run_period(7, 12, P - 12, "R4 R5 R6");
        run_period(7, 12, P - 12, "R4 R5 R6");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule